// File: doc/BRIEF.md
# Daisy-Chained Bus Access Handshake Controller

This controller obtains a shared bus for one device that sits on a fixed interrupt level. A request is latched when interrupts are enabled and either a transfer request or a transfer error occurs. The latched request is raised toward the bus controller. The controller answers with a level select and a priority-chain grant that travels from device to device. A device that is neither requesting nor selected forwards the chain grant to the next device. A device that is selected captures the grant, acknowledges the select and stops the chain.

When the bus controller has dropped select and the incoming grant has fallen, the device takes ownership of the bus and signals the start of ownership for one cycle. A programmable number of clock cycles later it asserts the bus strobe, which also withdraws the acknowledge. The receiving master answers with done, which clears the latched request. When done is released, ownership and strobe end, and the done-seen state clears one cycle after that. An optional timeout ends an exchange that never receives done. All bus-side inputs (select, chain grant and done) pass through two-flop synchronizers.

Top module: `bus_access_ctl`

## Requirements
- R1: The active-low reset `rst_n` or a one-cycle `bus_clear` pulse empties all handshake state. On the following cycle `svc_req`, `sel_ack`, `bus_own`, `strobe`, `own_begun` and `timeout_err` are 0.
- R2: The request latch sets only when `irq_en` is 1 and either `xfer_req` or `err_req` is 1. With `irq_en` at 0 both request inputs have no effect, and `svc_req` stays 0.
- R3: A set request latch drives `svc_req` to 1 while the device holds neither the grant nor ownership.
- R4: `chain_out` follows the synchronized `chain_in` only while the device is not requesting, not selected and neither granted nor owning. Otherwise `chain_out` is 0.
- R5: A synchronized chain grant that arrives while select is high and a request is latched sets the grant state. This raises `sel_ack`, drops `svc_req` and keeps `chain_out` at 0.
- R6: Ownership begins only after select has dropped and the synchronized chain grant is 0. `bus_own` then rises, and `own_begun` is 1 for exactly the first cycle of ownership.
- R7: `strobe` rises exactly `STB_DLY` clock cycles after `bus_own` rises, and `sel_ack` is 0 from the cycle after that.
- R8: Synchronized done during the strobe clears the request latch, and `svc_req` stays 0 afterwards. Strobe and ownership hold until done is released.
- R9: After done is released, `bus_own` and `strobe` fall together. The done-seen state clears on the next cycle.
- R10: With `TMO_EN`=1, `timeout_err` pulses high `TMO_CYC` cycles after `strobe` rises if no done arrives. In the same cycle `bus_own` and `strobe` are 0, and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clear | input | 1 | Synchronous clear from bus master reset or status write |
| irq_en | input | 1 | Interrupts enabled by the control register |
| xfer_req | input | 1 | Data-transfer request |
| err_req | input | 1 | Transfer-error request |
| sel_in | input | 1 | Level select from the bus controller (asynchronous) |
| chain_in | input | 1 | Incoming priority-chain grant (asynchronous) |
| done_in | input | 1 | Done from the receiving master (asynchronous) |
| svc_req | output | 1 | Service request to the bus controller |
| sel_ack | output | 1 | Select acknowledge |
| chain_out | output | 1 | Outgoing priority-chain grant |
| bus_own | output | 1 | Bus-ownership flag |
| strobe | output | 1 | Bus strobe |
| own_begun | output | 1 | One-cycle pulse at the start of ownership |
| timeout_err | output | 1 | One-cycle pulse when done never arrives |

## Verification
A grant state that is stuck or set wrongly shows up two or three cycles after a chain edge. It appears either as `chain_out` leaking past a requesting device or as `sel_ack` that never rises. A wrong ownership condition or a wrong delay count moves the `bus_own` or `strobe` edge by at least one cycle, and the exact cycle counts measured from ownership catch this. A done-seen state that does not clear, or a request latch that is not cleared, leaves `svc_req`, `strobe` or `bus_own` at the wrong level within a few cycles of done being released.

// File: rtl/bus_access_ctl.sv
module bus_access_ctl #(
  parameter int STB_DLY = 10,
  parameter int TMO_EN  = 1,
  parameter int TMO_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clear,
  input  logic irq_en,
  input  logic xfer_req,
  input  logic err_req,
  input  logic sel_in,
  input  logic chain_in,
  input  logic done_in,
  output logic svc_req,
  output logic sel_ack,
  output logic chain_out,
  output logic bus_own,
  output logic strobe,
  output logic own_begun,
  output logic timeout_err
);
  localparam int CW = $clog2(STB_DLY + 1);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] STB_LAST = CW'(STB_DLY - 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

  logic [1:0] sel_sr, chn_sr, done_sr;
  logic sel_s, chn_s, done_s;
  logic req_q, grant_q, own_q, own_d, strb_q, seen_q;
  logic [CW-1:0] dcnt;
  logic strb_set, done_hit, release_hit, tmo_hit, tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sr  <= '0;
      chn_sr  <= '0;
      done_sr <= '0;
    end else begin
      sel_sr  <= {sel_sr[0], sel_in};
      chn_sr  <= {chn_sr[0], chain_in};
      done_sr <= {done_sr[0], done_in};
    end
  end

  assign sel_s  = sel_sr[1];
  assign chn_s  = chn_sr[1];
  assign done_s = done_sr[1];

  assign strb_set    = own_q & ~strb_q & (dcnt == STB_LAST);
  assign done_hit    = strb_q & done_s & ~seen_q;
  assign release_hit = seen_q & ~done_s & own_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              req_q <= 1'b0;
    else if (bus_clear)                      req_q <= 1'b0;
    else if (done_hit || tmo_hit)            req_q <= 1'b0;
    else if (irq_en && (xfer_req || err_req)) req_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  grant_q <= 1'b0;
    else if (bus_clear || strb_set || tmo_hit)   grant_q <= 1'b0;
    else if (req_q && sel_s && chn_s && !own_q)  grant_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= 1'b0;
      own_d  <= 1'b0;
      strb_q <= 1'b0;
      dcnt   <= '0;
    end else begin
      own_d <= own_q;
      if (bus_clear || release_hit || tmo_hit) begin
        own_q  <= 1'b0;
        strb_q <= 1'b0;
        dcnt   <= '0;
      end else if (!own_q) begin
        dcnt <= '0;
        if (grant_q && !sel_s && !chn_s) own_q <= 1'b1;
      end else if (strb_set) begin
        strb_q <= 1'b1;
      end else if (!strb_q) begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  seen_q <= 1'b0;
    else if (bus_clear)          seen_q <= 1'b0;
    else if (done_hit)           seen_q <= 1'b1;
    else if (seen_q && !own_q)   seen_q <= 1'b0;
  end

  generate
    if (TMO_EN != 0) begin : g_tmo
      logic [TW-1:0] tcnt;
      assign tmo_hit = strb_q & ~seen_q & ~done_s & (tcnt == TMO_LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tcnt  <= '0;
          tmo_q <= 1'b0;
        end else begin
          tmo_q <= tmo_hit & ~bus_clear;
          if (!strb_q || seen_q || tmo_hit || bus_clear) tcnt <= '0;
          else                                           tcnt <= tcnt + 1'b1;
        end
      end

      a_r10_timeout_ends_own: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_q |-> (!own_q && !strb_q && !req_q));
    end else begin : g_no_tmo
      assign tmo_hit = 1'b0;
      assign tmo_q   = 1'b0;
    end
  endgenerate

  assign svc_req     = req_q & ~grant_q & ~own_q & ~seen_q;
  assign sel_ack     = grant_q;
  assign chain_out   = chn_s & ~req_q & ~sel_s & ~grant_q & ~own_q;
  assign bus_own     = own_q;
  assign strobe      = strb_q;
  assign own_begun   = own_q & ~own_d;
  assign timeout_err = tmo_q;

  a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clear |=> (!req_q && !grant_q && !own_q && !strb_q && !seen_q));

  a_r5_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_q) |-> ($past(sel_s) && $past(chn_s) && $past(req_q)));

  a_r6_own_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_q) |-> ($past(grant_q) && !$past(sel_s) && !$past(chn_s)));

  a_r7_strobe_drops_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_q) |=> !grant_q);

  a_r7_strobe_in_own: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q |-> own_q);

  a_r9_seen_clears_late: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seen_q) |-> !$past(own_q));
endmodule

// File: tb/sim_bus_access_ctl.sv
module sim_bus_access_ctl;
  localparam int STB_DLY = 10;
  localparam int TMO_CYC = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clear = 0, irq_en = 0, xfer_req = 0, err_req = 0;
  logic sel_in = 0, chain_in = 0, done_in = 0;
  logic svc_req, sel_ack, chain_out, bus_own, strobe, own_begun, timeout_err;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  bus_access_ctl #(.STB_DLY(STB_DLY), .TMO_EN(1), .TMO_CYC(TMO_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_clear(bus_clear), .irq_en(irq_en),
    .xfer_req(xfer_req), .err_req(err_req), .sel_in(sel_in),
    .chain_in(chain_in), .done_in(done_in), .svc_req(svc_req),
    .sel_ack(sel_ack), .chain_out(chain_out), .bus_own(bus_own),
    .strobe(strobe), .own_begun(own_begun), .timeout_err(timeout_err));

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset;
    check("R1", "svc_req after reset", svc_req, 0);
    check("R1", "sel_ack after reset", sel_ack, 0);
    check("R1", "bus_own after reset", bus_own, 0);
    check("R1", "strobe after reset", strobe, 0);
    check("R1", "timeout_err after reset", timeout_err, 0);
  endtask

  task automatic test_irq_off;
    irq_en = 0; xfer_req = 1; err_req = 1;
    step(4);
    check("R2", "svc_req with irq_en=0", svc_req, 0);
    xfer_req = 0; err_req = 0; irq_en = 1;
    step(2);
    check("R2", "svc_req stays 0 after requests drop", svc_req, 0);
  endtask

  task automatic test_pass;
    chain_in = 1;
    step(3);
    check("R4", "chain_out passes when idle", chain_out, 1);
    sel_in = 1;
    step(3);
    check("R4", "chain_out blocked by select", chain_out, 0);
    check("R5", "no ack without request", sel_ack, 0);
    sel_in = 0; chain_in = 0;
    step(3);
    check("R4", "chain_out low after grant drop", chain_out, 0);
  endtask

  task automatic run_xfer(input bit use_err);
    int n;
    if (use_err) err_req = 1; else xfer_req = 1;
    step(1);
    err_req = 0; xfer_req = 0;
    step(1);
    check("R3", "svc_req raised", svc_req, 1);
    chain_in = 1;
    step(3);
    check("R4", "chain_out blocked while requesting", chain_out, 0);
    sel_in = 1;
    step(3);
    check("R5", "sel_ack raised", sel_ack, 1);
    check("R5", "svc_req withdrawn", svc_req, 0);
    check("R5", "chain_out held low", chain_out, 0);
    sel_in = 0;
    step(4);
    check("R6", "no ownership while chain high", bus_own, 0);
    chain_in = 0;
    n = 0;
    while (!bus_own && n < 20) begin step(1); n++; end
    check("R6", "bus_own raised", bus_own, 1);
    check("R6", "own_begun in first cycle", own_begun, 1);
    n = 0;
    step(1); n++;
    check("R6", "own_begun one cycle only", own_begun, 0);
    while (!strobe && n < 50) begin step(1); n++; end
    check("R7", "strobe delay cycles", n, STB_DLY);
    step(1);
    check("R7", "sel_ack dropped after strobe", sel_ack, 0);
    step(3);
    done_in = 1;
    step(5);
    check("R8", "strobe held during done", strobe, 1);
    check("R8", "bus_own held during done", bus_own, 1);
    check("R8", "svc_req low during done", svc_req, 0);
    done_in = 0;
    n = 0;
    while (bus_own && n < 20) begin step(1); n++; end
    check("R9", "bus_own released", bus_own, 0);
    check("R9", "strobe falls with ownership", strobe, 0);
    step(3);
    check("R8", "request latch cleared by done", svc_req, 0);
  endtask

  task automatic test_timeout;
    int n;
    xfer_req = 1; step(1); xfer_req = 0;
    chain_in = 1; sel_in = 1;
    step(4);
    sel_in = 0; chain_in = 0;
    n = 0;
    while (!strobe && n < 60) begin step(1); n++; end
    check("R10", "strobe reached before timeout", strobe, 1);
    n = 0;
    while (!timeout_err && n < TMO_CYC + 20) begin step(1); n++; end
    check("R10", "timeout cycles after strobe", n, TMO_CYC);
    check("R10", "bus_own off at timeout", bus_own, 0);
    check("R10", "strobe off at timeout", strobe, 0);
    step(1);
    check("R10", "timeout_err one cycle", timeout_err, 0);
    check("R10", "request dropped", svc_req, 0);
  endtask

  task automatic test_clear;
    int n;
    xfer_req = 1; step(1); xfer_req = 0;
    chain_in = 1; sel_in = 1;
    step(4);
    sel_in = 0; chain_in = 0;
    n = 0;
    while (!bus_own && n < 20) begin step(1); n++; end
    check("R1", "owning before clear", bus_own, 1);
    bus_clear = 1; step(1); bus_clear = 0;
    check("R1", "bus_own cleared", bus_own, 0);
    check("R1", "svc_req cleared", svc_req, 0);
    check("R1", "sel_ack cleared", sel_ack, 0);
    step(STB_DLY + 2);
    check("R1", "no strobe after clear", strobe, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    test_reset();
    test_irq_off();
    test_pass();
    run_xfer(0);
    step(4);
    run_xfer(1);
    step(4);
    test_timeout();
    step(4);
    test_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule